// File: doc/BRIEF.md
# Multi-channel DMA request router

This block sits between the transfer engine of a multi-buffered serial peripheral and a system DMA controller. It holds eight independent channels. Each channel is tied to one slot of the peripheral's buffer array. When the engine reports that a slot is ready to take new transmit data, or that a slot has been filled by a finished transfer, the channel bound to that slot records a pending transmit or receive request. The channel then raises that request on whichever of the sixteen shared DMA request lines software has chosen for it.

Every channel has its own transmit line select and its own receive line select. Each select is decoded one-hot, and the results of all channels are ORed per line. When the DMA controller acknowledges a line, exactly one pending source on that line is retired. Each channel counts the words it has moved. A short count of up to 32 words is always available. An extended 16-bit count allows up to 65535 words through the same single slot. When the count runs out, the channel goes idle, drops its requests and raises a sticky completion flag. Software clears that flag.

Requests come only from the per-channel enables and selects. No global enable takes part. All traffic is aimed at the buffer array.

Top module: `dma_req_router`

## Requirements
- R1: While reset is high, and on the first clock edge after it, `dma_req` and `ch_done` are all zero.
- R2: On an active channel with its transmit enable set, a `tx_rdy_vld` strobe whose `tx_rdy_buf` equals the channel's buffer index sets a pending transmit request. `dma_req` bit `cfg_tx_sel` (a 4-bit field per channel at bits [4c+3:4c]) rises two clock edges after the strobe is sampled.
- R3: A `rx_full_vld` strobe on the bound buffer likewise raises line `cfg_rx_sel` when the receive enable is set. A channel with both enables set can hold a transmit and a receive request at the same time.
- R4: A strobe is ignored if its buffer index differs from the channel's index, if its direction is disabled, or if the channel is not active.
- R5: Each request line is the OR of every pending source routed to it. A line shared by two channels stays high while either one still has a request pending.
- R6: A `dma_ack` bit retires exactly one pending source routed to that line. The winner is the lowest channel number, and within a channel the transmit source wins over the receive source. The line drops one edge after the ack only if no other source remains.
- R7: A word counts as finished on an acknowledged receive request if receive is enabled, and otherwise on an acknowledged transmit request. In short mode (`cfg_ext_en`=0) the block length is `cfg_short_len`+1, from 1 to 32 words, and `cfg_ext_len` is ignored.
- R8: With `cfg_ext_en`=1 the block length is `cfg_ext_len` (up to 65535) and `cfg_short_len` is ignored. A length of 0 sets the completion flag at the start edge and leaves the channel idle.
- R9: When the last word finishes, on that same edge the channel goes idle, clears both pending requests and sets `ch_done`. Later strobes raise no request.
- R10: `ch_done` stays set until a `done_clr` or `ch_start` pulse for that channel. If completion and `done_clr` happen on the same edge, the flag is set.
- R11: A `ch_start` pulse reloads the count, clears the channel's pending requests, and makes the channel active when the loaded length is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_en | input | NUM_CH | Per-channel transmit request enable |
| cfg_rx_en | input | NUM_CH | Per-channel receive request enable |
| cfg_ext_en | input | NUM_CH | Per-channel extended 16-bit count select |
| cfg_buf_idx | input | NUM_CH*BUF_W | Buffer slot bound to each channel |
| cfg_tx_sel | input | NUM_CH*4 | Request line for each channel's transmit request |
| cfg_rx_sel | input | NUM_CH*4 | Request line for each channel's receive request |
| cfg_short_len | input | NUM_CH*5 | Short block length minus one |
| cfg_ext_len | input | NUM_CH*CNT_W | Extended block length |
| ch_start | input | NUM_CH | Arm or re-arm a channel |
| done_clr | input | NUM_CH | Clear a channel's completion flag |
| tx_rdy_vld | input | 1 | Strobe: a slot is ready to take transmit data |
| tx_rdy_buf | input | BUF_W | Slot index for tx_rdy_vld |
| rx_full_vld | input | 1 | Strobe: a slot holds received data |
| rx_full_buf | input | BUF_W | Slot index for rx_full_vld |
| dma_ack | input | NUM_LINES | Per-line acknowledge from the DMA controller |
| dma_req | output | NUM_LINES | Registered request lines |
| ch_done | output | NUM_CH | Sticky per-channel completion flags |

## Verification
The bench builds the block with eight channels, sixteen lines, a 16-bit count and a 4-bit buffer index. The narrow index means random engine strobes hit bound slots often, and channels frequently share slots and lines. That brings collisions on a single line, same-edge acks and strobes, and completions racing clears within reach of random traffic. The 16-bit count lets a directed run walk a 600-word extended block next to full 32-word short blocks and the zero-length case.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

  // Width of the short block length field (length minus one, 1..32 words)
  localparam int SHORT_W = 5;

  // Source kind inside one channel; lower value wins line arbitration
  typedef enum logic {
    SRC_TX = 1'b0,
    SRC_RX = 1'b1
  } dmar_src_e;

endpackage

// File: rtl/dmar_channel.sv
module dmar_channel
  import dmar_pkg::*;
#(
  parameter int BUF_W = 7,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_tx_en,
  input  logic               cfg_rx_en,
  input  logic               cfg_ext_en,
  input  logic [BUF_W-1:0]   cfg_buf,
  input  logic [SHORT_W-1:0] cfg_short_len,
  input  logic [CNT_W-1:0]   cfg_ext_len,
  input  logic               start,
  input  logic               clr,
  input  logic               tx_rdy_vld,
  input  logic [BUF_W-1:0]   tx_rdy_buf,
  input  logic               rx_full_vld,
  input  logic [BUF_W-1:0]   rx_full_buf,
  input  logic               tx_grant,
  input  logic               rx_grant,
  output logic               tx_pend,
  output logic               rx_pend,
  output logic               active,
  output logic               done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             tx_hit, rx_hit, word, last;

  always_comb begin
    load_val = cfg_ext_en ? cfg_ext_len : (CNT_W'(cfg_short_len) + CNT_W'(1));
    tx_hit   = active && cfg_tx_en && tx_rdy_vld  && (tx_rdy_buf  == cfg_buf);
    rx_hit   = active && cfg_rx_en && rx_full_vld && (rx_full_buf == cfg_buf);
    word     = active && (cfg_rx_en ? rx_grant : tx_grant);
    last     = word && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      active  <= 1'b0;
      tx_pend <= 1'b0;
      rx_pend <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      cnt_q   <= load_val;
      active  <= (load_val != '0);
      tx_pend <= 1'b0;
      rx_pend <= 1'b0;
      done    <= (load_val == '0);
    end else if (last) begin
      cnt_q   <= '0;
      active  <= 1'b0;
      tx_pend <= 1'b0;
      rx_pend <= 1'b0;
      done    <= 1'b1;
    end else begin
      if (clr) done <= 1'b0;
      if (active) begin
        cnt_q   <= cnt_q - CNT_W'(word);
        tx_pend <= (tx_pend && !tx_grant) || tx_hit;
        rx_pend <= (rx_pend && !rx_grant) || rx_hit;
      end
    end
  end

endmodule

// File: rtl/dmar_ack_arbiter.sv
module dmar_ack_arbiter
  import dmar_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_LINES = 16,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_CH-1:0]       tx_pend,
  input  logic [NUM_CH-1:0]       rx_pend,
  input  logic [NUM_CH*SEL_W-1:0] tx_sel,
  input  logic [NUM_CH*SEL_W-1:0] rx_sel,
  input  logic [NUM_LINES-1:0]    dma_ack,
  output logic [NUM_CH-1:0]       tx_grant,
  output logic [NUM_CH-1:0]       rx_grant
);

  logic             taken;
  logic             src_pend;
  logic [SEL_W-1:0] src_sel;
  dmar_src_e        kind;

  // Per line: first pending source in order ch0.tx, ch0.rx, ch1.tx, ...
  always_comb begin
    tx_grant = '0;
    rx_grant = '0;
    taken    = 1'b0;
    src_pend = 1'b0;
    src_sel  = '0;
    kind     = SRC_TX;
    for (int l = 0; l < NUM_LINES; l++) begin
      taken = 1'b0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        for (int s = 0; s < 2; s++) begin
          kind     = dmar_src_e'(s);
          src_pend = (kind == SRC_RX) ? rx_pend[ch] : tx_pend[ch];
          src_sel  = (kind == SRC_RX) ? rx_sel[ch*SEL_W +: SEL_W] : tx_sel[ch*SEL_W +: SEL_W];
          if (dma_ack[l] && !taken && src_pend && (src_sel == SEL_W'(l))) begin
            taken = 1'b1;
            if (kind == SRC_RX) rx_grant[ch] = 1'b1;
            else                tx_grant[ch] = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dmar_line_combine.sv
module dmar_line_combine #(
  parameter int NUM_CH    = 8,
  parameter int NUM_LINES = 16,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       tx_pend,
  input  logic [NUM_CH-1:0]       rx_pend,
  input  logic [NUM_CH*SEL_W-1:0] tx_sel,
  input  logic [NUM_CH*SEL_W-1:0] rx_sel,
  output logic [NUM_LINES-1:0]    req_q
);

  logic [NUM_CH-1:0][NUM_LINES-1:0] tx_dec, rx_dec;
  logic [NUM_LINES-1:0]             req_d;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
    assign tx_dec[ch] = tx_pend[ch] ? (NUM_LINES'(1) << tx_sel[ch*SEL_W +: SEL_W]) : '0;
    assign rx_dec[ch] = rx_pend[ch] ? (NUM_LINES'(1) << rx_sel[ch*SEL_W +: SEL_W]) : '0;
  end

  always_comb begin
    req_d = '0;
    for (int ch = 0; ch < NUM_CH; ch++) req_d = req_d | tx_dec[ch] | rx_dec[ch];
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req_d;
  end

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmar_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_LINES = 16,
  parameter int BUF_W     = 7,
  parameter int CNT_W     = 16,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CH-1:0]         cfg_tx_en,
  input  logic [NUM_CH-1:0]         cfg_rx_en,
  input  logic [NUM_CH-1:0]         cfg_ext_en,
  input  logic [NUM_CH*BUF_W-1:0]   cfg_buf_idx,
  input  logic [NUM_CH*SEL_W-1:0]   cfg_tx_sel,
  input  logic [NUM_CH*SEL_W-1:0]   cfg_rx_sel,
  input  logic [NUM_CH*SHORT_W-1:0] cfg_short_len,
  input  logic [NUM_CH*CNT_W-1:0]   cfg_ext_len,
  input  logic [NUM_CH-1:0]         ch_start,
  input  logic [NUM_CH-1:0]         done_clr,
  input  logic                      tx_rdy_vld,
  input  logic [BUF_W-1:0]          tx_rdy_buf,
  input  logic                      rx_full_vld,
  input  logic [BUF_W-1:0]          rx_full_buf,
  input  logic [NUM_LINES-1:0]      dma_ack,
  output logic [NUM_LINES-1:0]      dma_req,
  output logic [NUM_CH-1:0]         ch_done
);

  logic [NUM_CH-1:0] tx_pend, rx_pend, ch_active;
  logic [NUM_CH-1:0] tx_grant, rx_grant;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dmar_channel #(.BUF_W(BUF_W), .CNT_W(CNT_W)) chan_i (
      .clk           (clk),
      .rst           (rst),
      .cfg_tx_en     (cfg_tx_en[ch]),
      .cfg_rx_en     (cfg_rx_en[ch]),
      .cfg_ext_en    (cfg_ext_en[ch]),
      .cfg_buf       (cfg_buf_idx[ch*BUF_W +: BUF_W]),
      .cfg_short_len (cfg_short_len[ch*SHORT_W +: SHORT_W]),
      .cfg_ext_len   (cfg_ext_len[ch*CNT_W +: CNT_W]),
      .start         (ch_start[ch]),
      .clr           (done_clr[ch]),
      .tx_rdy_vld    (tx_rdy_vld),
      .tx_rdy_buf    (tx_rdy_buf),
      .rx_full_vld   (rx_full_vld),
      .rx_full_buf   (rx_full_buf),
      .tx_grant      (tx_grant[ch]),
      .rx_grant      (rx_grant[ch]),
      .tx_pend       (tx_pend[ch]),
      .rx_pend       (rx_pend[ch]),
      .active        (ch_active[ch]),
      .done          (ch_done[ch])
    );
  end

  dmar_ack_arbiter #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) arb_i (
    .tx_pend  (tx_pend),
    .rx_pend  (rx_pend),
    .tx_sel   (cfg_tx_sel),
    .rx_sel   (cfg_rx_sel),
    .dma_ack  (dma_ack),
    .tx_grant (tx_grant),
    .rx_grant (rx_grant)
  );

  dmar_line_combine #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) comb_i (
    .clk     (clk),
    .rst     (rst),
    .tx_pend (tx_pend),
    .rx_pend (rx_pend),
    .tx_sel  (cfg_tx_sel),
    .rx_sel  (cfg_rx_sel),
    .req_q   (dma_req)
  );

endmodule

// File: rtl/dmar_checker.sv
module dmar_checker #(
  parameter int NUM_CH    = 8,
  parameter int NUM_LINES = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] dma_req,
  input logic [NUM_LINES-1:0] dma_ack,
  input logic [NUM_CH-1:0]    ch_done,
  input logic [NUM_CH-1:0]    ch_start,
  input logic [NUM_CH-1:0]    done_clr,
  input logic [NUM_CH-1:0]    tx_pend,
  input logic [NUM_CH-1:0]    rx_pend,
  input logic [NUM_CH-1:0]    ch_active,
  input logic [NUM_CH-1:0]    tx_grant,
  input logic [NUM_CH-1:0]    rx_grant
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (dma_req == '0 && ch_done == '0));

  a_r5_idle_lines_low: assert property (@(posedge clk) disable iff (rst)
    (tx_pend == '0 && rx_pend == '0) |=> (dma_req == '0));

  a_r6_one_grant_per_ack: assert property (@(posedge clk) disable iff (rst)
    $countones({tx_grant, rx_grant}) <= $countones(dma_ack));

  a_r6_grant_needs_pending: assert property (@(posedge clk) disable iff (rst)
    ((tx_grant & ~tx_pend) | (rx_grant & ~rx_pend)) == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r9_pending_only_active: assert property (@(posedge clk) disable iff (rst)
      (tx_pend[c] || rx_pend[c]) |-> ch_active[c]);

    a_r9_done_means_idle: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_done[c]) |-> !ch_active[c]);

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
      (ch_done[c] && !done_clr[c] && !ch_start[c]) |=> ch_done[c]);

    a_r10_idle_clear: assert property (@(posedge clk) disable iff (rst)
      (done_clr[c] && !ch_start[c] && !ch_active[c]) |=> !ch_done[c]);
  end

endmodule

bind dma_req_router dmar_checker #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) chk_i (.*);

// File: tb/dma_req_router_tb.sv
module dma_req_router_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 8;
  localparam int NL   = 16;
  localparam int BW   = 4;
  localparam int CW   = 16;
  localparam int SELW = 4;
  localparam int SW   = 5;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0]      tx_en, rx_en, ext_en, start, clr;
  logic [NCH*BW-1:0]   buf_idx;
  logic [NCH*SELW-1:0] tx_sel, rx_sel;
  logic [NCH*SW-1:0]   short_len;
  logic [NCH*CW-1:0]   ext_len;
  logic                txv, rxv;
  logic [BW-1:0]       txb, rxb;
  logic [NL-1:0]       ack;
  logic [NL-1:0]       dma_req;
  logic [NCH-1:0]      ch_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_router #(.NUM_CH(NCH), .NUM_LINES(NL), .BUF_W(BW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_tx_en(tx_en), .cfg_rx_en(rx_en), .cfg_ext_en(ext_en),
    .cfg_buf_idx(buf_idx), .cfg_tx_sel(tx_sel), .cfg_rx_sel(rx_sel),
    .cfg_short_len(short_len), .cfg_ext_len(ext_len),
    .ch_start(start), .done_clr(clr),
    .tx_rdy_vld(txv), .tx_rdy_buf(txb), .rx_full_vld(rxv), .rx_full_buf(rxb),
    .dma_ack(ack), .dma_req(dma_req), .ch_done(ch_done)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  bit finished = 1'b0;

  // reference model state
  bit [NCH-1:0] m_tp, m_rp, m_act, m_done;
  int           m_cnt [NCH];
  logic [NL-1:0] m_req;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int load_of(int c);
    if (ext_en[c]) return int'(ext_len[c*CW +: CW]);
    return int'(short_len[c*SW +: SW]) + 1;
  endfunction

  task automatic model_reset();
    m_tp = '0; m_rp = '0; m_act = '0; m_done = '0; m_req = '0;
    for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
  endtask

  task automatic model_step();
    bit [NCH-1:0] tg, rg;
    bit taken;
    bit word;
    int ld;
    tg = '0; rg = '0;
    for (int l = 0; l < NL; l++) begin
      taken = 1'b0;
      if (ack[l]) begin
        for (int c = 0; c < NCH; c++) begin
          if (!taken && m_tp[c] && int'(tx_sel[c*SELW +: SELW]) == l) begin tg[c] = 1'b1; taken = 1'b1; end
          if (!taken && m_rp[c] && int'(rx_sel[c*SELW +: SELW]) == l) begin rg[c] = 1'b1; taken = 1'b1; end
        end
      end
    end
    m_req = '0;
    for (int c = 0; c < NCH; c++) begin
      if (m_tp[c]) m_req[tx_sel[c*SELW +: SELW]] = 1'b1;
      if (m_rp[c]) m_req[rx_sel[c*SELW +: SELW]] = 1'b1;
    end
    for (int c = 0; c < NCH; c++) begin
      ld = load_of(c);
      if (start[c]) begin
        m_cnt[c] = ld; m_act[c] = (ld != 0); m_tp[c] = 1'b0; m_rp[c] = 1'b0; m_done[c] = (ld == 0);
      end else begin
        word = m_act[c] && (rx_en[c] ? rg[c] : tg[c]);
        if (word && m_cnt[c] == 1) begin
          m_cnt[c] = 0; m_act[c] = 1'b0; m_tp[c] = 1'b0; m_rp[c] = 1'b0; m_done[c] = 1'b1;
        end else begin
          if (clr[c]) m_done[c] = 1'b0;
          if (m_act[c]) begin
            m_cnt[c] = m_cnt[c] - int'(word);
            m_tp[c] = (m_tp[c] && !tg[c]) || (tx_en[c] && txv && txb == buf_idx[c*BW +: BW]);
            m_rp[c] = (m_rp[c] && !rg[c]) || (rx_en[c] && rxv && rxb == buf_idx[c*BW +: BW]);
          end
        end
      end
    end
  endtask

  // one clock: advance model at the edge, compare at the following falling edge
  task automatic tick();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    check({cur_tag, " model req"}, 32'(dma_req), 32'(m_req));
    check({cur_tag, " model done"}, 32'(ch_done), 32'(m_done));
  endtask

  task automatic idle_inputs();
    start = '0; clr = '0; txv = 1'b0; rxv = 1'b0; txb = '0; rxb = '0; ack = '0;
  endtask

  task automatic cfg_ch(int c, bit te, bit re, bit ee, int b, int ts, int rs, int sl, int el);
    tx_en[c] = te; rx_en[c] = re; ext_en[c] = ee;
    buf_idx[c*BW +: BW] = BW'(b);
    tx_sel[c*SELW +: SELW] = SELW'(ts);
    rx_sel[c*SELW +: SELW] = SELW'(rs);
    short_len[c*SW +: SW] = SW'(sl);
    ext_len[c*CW +: CW] = CW'(el);
  endtask

  task automatic pulse_start(int c);
    start[c] = 1'b1; tick(); start[c] = 1'b0;
  endtask

  task automatic tx_word(int b, int line);
    txv = 1'b1; txb = BW'(b); tick();
    txv = 1'b0; tick();
    ack[line] = 1'b1; tick(); ack[line] = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tx_en = '0; rx_en = '0; ext_en = '0; buf_idx = '0; tx_sel = '0; rx_sel = '0;
    short_len = '0; ext_len = '0;
    idle_inputs();
    model_reset();
    rst = 1'b1;
    @(negedge clk);
    tick(); tick();
    check("R1 reset req", 32'(dma_req), 32'h0);
    check("R1 reset done", 32'(ch_done), 32'h0);
    rst = 1'b0;
    tick();

    // R2: transmit request on line 3 from slot 5
    cur_tag = "R2";
    cfg_ch(0, 1, 0, 0, 5, 3, 0, 2, 0);
    pulse_start(0);
    txv = 1'b1; txb = 4'd5; tick(); txv = 1'b0;
    check("R2 not yet", 32'(dma_req), 32'h0);
    tick();
    check("R2 tx line 3", 32'(dma_req), 32'h0008);

    // R6: ack retires it
    cur_tag = "R6";
    ack[3] = 1'b1; tick(); ack[3] = 1'b0;
    tick();
    check("R6 line drops", 32'(dma_req), 32'h0);

    // R4: wrong slot, and rx strobe on a tx-only channel
    cur_tag = "R4";
    txv = 1'b1; txb = 4'd6; rxv = 1'b1; rxb = 4'd5; tick(); txv = 1'b0; rxv = 1'b0;
    tick();
    check("R4 ignored strobes", 32'(dma_req), 32'h0);

    // R3/R7: both directions, word counted on rx ack
    cur_tag = "R3";
    cfg_ch(1, 1, 1, 0, 2, 7, 9, 0, 0);
    pulse_start(1);
    txv = 1'b1; txb = 4'd2; rxv = 1'b1; rxb = 4'd2; tick(); txv = 1'b0; rxv = 1'b0;
    tick();
    check("R3 tx and rx lines", 32'(dma_req), 32'h0280);
    cur_tag = "R7";
    ack[7] = 1'b1; tick(); ack[7] = 1'b0;
    tick();
    check("R7 tx ack no count", 32'(ch_done[1]), 32'h0);
    check("R7 rx still up", 32'(dma_req), 32'h0200);
    cur_tag = "R9";
    ack[9] = 1'b1; tick(); ack[9] = 1'b0;
    check("R9 done on last word", 32'(ch_done[1]), 32'h1);
    tick();
    check("R9 lines dropped", 32'(dma_req), 32'h0);
    txv = 1'b1; txb = 4'd2; tick(); txv = 1'b0; tick();
    check("R9 idle ignores strobe", 32'(dma_req), 32'h0);

    // R10: clear
    cur_tag = "R10";
    clr[1] = 1'b1; tick(); clr[1] = 1'b0;
    check("R10 clear", 32'(ch_done[1]), 32'h0);

    // R5/R6: shared line 4
    cur_tag = "R5";
    cfg_ch(2, 1, 0, 0, 8, 4, 0, 31, 0);
    cfg_ch(3, 1, 0, 0, 9, 4, 0, 31, 0);
    start[2] = 1'b1; start[3] = 1'b1; tick(); start = '0;
    txv = 1'b1; txb = 4'd8; tick(); txb = 4'd9; tick(); txv = 1'b0;
    tick();
    check("R5 shared line up", 32'(dma_req), 32'h0010);
    ack[4] = 1'b1; tick(); ack[4] = 1'b0; tick();
    check("R5 shared line stays", 32'(dma_req), 32'h0010);
    cur_tag = "R6";
    ack[4] = 1'b1; tick(); ack[4] = 1'b0; tick();
    check("R6 second ack empties line", 32'(dma_req), 32'h0);

    // R10: completion beats clear on the same edge
    cur_tag = "R10";
    cfg_ch(4, 1, 0, 0, 11, 12, 0, 0, 0);
    pulse_start(4);
    txv = 1'b1; txb = 4'd11; tick(); txv = 1'b0; tick();
    ack[12] = 1'b1; clr[4] = 1'b1; tick(); ack[12] = 1'b0; clr[4] = 1'b0;
    check("R10 set wins", 32'(ch_done[4]), 32'h1);

    // R8: zero extended length, then 600 words with short field ignored
    cur_tag = "R8";
    cfg_ch(5, 1, 0, 1, 13, 14, 0, 0, 0);
    pulse_start(5);
    check("R8 zero length done", 32'(ch_done[5]), 32'h1);
    cfg_ch(5, 1, 0, 1, 13, 14, 0, 0, 600);
    pulse_start(5);
    check("R8 start clears done", 32'(ch_done[5]), 32'h0);
    tx_word(13, 14);
    check("R8 short field ignored", 32'(ch_done[5]), 32'h0);
    for (int w = 1; w < 599; w++) tx_word(13, 14);
    check("R8 599 words not done", 32'(ch_done[5]), 32'h0);
    tx_word(13, 14);
    check("R8 600 words done", 32'(ch_done[5]), 32'h1);

    // R7: 32-word short block
    cur_tag = "R7";
    cfg_ch(7, 1, 0, 0, 15, 1, 0, 31, 5);
    pulse_start(7);
    for (int w = 0; w < 31; w++) tx_word(15, 1);
    check("R7 31 of 32", 32'(ch_done[7]), 32'h0);
    tx_word(15, 1);
    check("R7 32 of 32", 32'(ch_done[7]), 32'h1);

    // R11: restart drops pending request
    cur_tag = "R11";
    cfg_ch(6, 1, 0, 0, 3, 6, 0, 3, 0);
    pulse_start(6);
    txv = 1'b1; txb = 4'd3; tick(); txv = 1'b0;
    pulse_start(6);
    tick();
    check("R11 restart clears pending", 32'(dma_req), 32'h0);

    // random traffic against the model
    cur_tag = "R5";
    for (int round = 0; round < 4; round++) begin
      for (int c = 0; c < NCH; c++)
        cfg_ch(c, $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
               $urandom_range(0, 31), $urandom_range(0, 40));
      start = '1; tick(); start = '0;
      for (int cyc = 0; cyc < 600; cyc++) begin
        txv = $urandom_range(0, 1); txb = BW'($urandom);
        rxv = $urandom_range(0, 1); rxb = BW'($urandom);
        ack = NL'($urandom) & NL'($urandom);
        for (int c = 0; c < NCH; c++) begin
          start[c] = ($urandom_range(0, 63) == 0);
          clr[c]   = ($urandom_range(0, 15) == 0);
        end
        tick();
      end
      idle_inputs();
      tick();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule